// File: doc/BRIEF.md
# GPIO Port with Interrupt Cause Logic

This block is a 32-line general-purpose I/O port controlled through a small word-addressed register window. Each line can drive a value or float its driver and act as an input. Inputs are brought into the clock domain by a two-stage synchronizer. A per-line inversion bit is applied to the synchronized level, and the adjusted level is what software reads back and what the interrupt logic watches.

Rising transitions of the adjusted level are latched into a sticky cause register, so one detector serves both edge directions: clearing the inversion bit catches rising pins and setting it catches falling pins. Software clears cause bits by writing zeros to them. Every line raises a request from its adjusted level through a level mask, or from its latched cause through an edge mask. The requests are ORed in groups of eight, giving four summary interrupt lines. Any output line can also be set to blink, driven by a free-running prescaler.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the output, blink, polarity, edge-cause, edge-mask and level-mask registers read zero, the direction register reads all ones (every line an input), `pin_oe` is zero and `irq_group` is zero.
- R2: The registers sit at byte offsets 0x00 output value, 0x04 direction, 0x08 blink enable, 0x0C input polarity, 0x10 adjusted input (read-only), 0x14 edge cause, 0x18 edge mask and 0x1C level mask. The read data is combinational in the cycle of the access. Offsets that are not listed, including any address that is not word-aligned, read as zero and ignore writes. A write to 0x10 has no effect.
- R3: A direction bit of 1 sets the line's `pin_oe` bit to 0. A direction bit of 0 sets `pin_oe` to 1, and `pin_out` then follows the output-value bit whenever blink is off for that line.
- R4: Reading 0x10 returns the pin level delayed by two clock edges, XORed with the polarity bit. A pin change driven before edge k becomes visible after edge k+1.
- R5: An edge-cause bit is set when the adjusted input of its line goes from 0 to 1, one edge after that change is visible at 0x10 (three edges after the pin change). With polarity 0 this catches a rising pin and with polarity 1 a falling pin.
- R6: A write to 0x14 clears each cause bit written as 0 and leaves each bit written as 1 unchanged.
- R7: If a new edge event and a clearing write reach the same cause bit in the same cycle, the bit ends up set.
- R8: A line's request is (adjusted input AND level mask) OR (edge cause AND edge mask). `irq_group[g]` is the OR of the requests of lines 8g to 8g+7.
- R9: A line whose blink bit is 1 and whose direction bit is 0 drives a square wave on `pin_out` that toggles every `BLINK_DIV` clock cycles. When the blink bit is 0, the line drives its output-value bit.
- R10: Cause bits are latched whatever the edge mask holds, and they stay set after the input returns to its previous level until software clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pin_out | output | 32 | Value driven on each pin |
| pin_oe | output | 32 | Driver enable per pin, 1 = drive |
| irq_group | output | 4 | Summary interrupt per group of eight lines |

## Verification
The assertions assume that `pin_in` is stable around the sampling edge. They also assume that the bus signals do not change at a clock edge, so that the cause-clear and unmapped-read properties see exactly the access the register bank decodes. The bench changes pins and bus signals only on falling clock edges, and it keeps each access one cycle long. It holds a pin change for at least three cycles before judging the cause. For the race case it times the clearing write so that the write lands on the edge where the new event is latched.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Register slot index = byte offset / 4; software relies on this order.
    typedef enum logic [2:0] {
        SLOT_OUT   = 3'd0,
        SLOT_DIR   = 3'd1,
        SLOT_BLINK = 3'd2,
        SLOT_POL   = 3'd3,
        SLOT_DIN   = 3'd4,
        SLOT_CAUSE = 3'd5,
        SLOT_EMASK = 3'd6,
        SLOT_LMASK = 3'd7
    } slot_e;

    localparam int unsigned SLOT_LSB  = 2;
    localparam int unsigned SLOT_BITS = 3;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = async_in;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q.stage2;
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } blink_t;

    blink_t blink_d, blink_q;

    always_comb begin
        blink_d = blink_q;
        if (blink_q.cnt == LAST) begin
            blink_d.cnt   = '0;
            blink_d.phase = ~blink_q.phase;
        end else begin
            blink_d.cnt = blink_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) blink_q <= '0;
        else        blink_q <= blink_d;
    end

    assign phase = blink_q.phase;
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_irq_pkg::*;
#(
    parameter int unsigned LINES  = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LINES-1:0]  sync_lvl,
    output logic [LINES-1:0]  din_adj,
    output logic [LINES-1:0]  out_q,
    output logic [LINES-1:0]  dir_q,
    output logic [LINES-1:0]  blink_q,
    output logic [LINES-1:0]  cause_q,
    output logic [LINES-1:0]  emask_q,
    output logic [LINES-1:0]  lmask_q
);
    localparam int unsigned WIN_TOP = SLOT_LSB + SLOT_BITS;

    typedef struct packed {
        logic [LINES-1:0] out;
        logic [LINES-1:0] dir;
        logic [LINES-1:0] blink;
        logic [LINES-1:0] pol;
        logic [LINES-1:0] cause;
        logic [LINES-1:0] emask;
        logic [LINES-1:0] lmask;
        logic [LINES-1:0] adj_prev;
    } bank_t;

    bank_t bank_d, bank_q;

    logic             in_window;
    slot_e            slot;
    logic             wr_en;
    logic [LINES-1:0] wr_val;
    logic [LINES-1:0] rise;
    logic [LINES-1:0] rd_val;

    always_comb begin
        in_window = (bus_addr[SLOT_LSB-1:0] == '0) &&
                    (bus_addr[ADDR_W-1:WIN_TOP] == '0);
        slot      = slot_e'(bus_addr[WIN_TOP-1:SLOT_LSB]);
        wr_en     = bus_sel && bus_wr && in_window;
        wr_val    = bus_wdata[LINES-1:0];
        din_adj   = sync_lvl ^ bank_q.pol;
        rise      = din_adj & ~bank_q.adj_prev;
    end

    always_comb begin
        bank_d          = bank_q;
        bank_d.adj_prev = din_adj;
        if (wr_en) begin
            unique case (slot)
                SLOT_OUT:   bank_d.out   = wr_val;
                SLOT_DIR:   bank_d.dir   = wr_val;
                SLOT_BLINK: bank_d.blink = wr_val;
                SLOT_POL:   bank_d.pol   = wr_val;
                SLOT_CAUSE: bank_d.cause = bank_q.cause & wr_val;
                SLOT_EMASK: bank_d.emask = wr_val;
                SLOT_LMASK: bank_d.lmask = wr_val;
                default:    ;
            endcase
        end
        // A new event wins over a clearing write in the same cycle.
        bank_d.cause = bank_d.cause | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q     <= '0;
            bank_q.dir <= '1;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rd_val = '0;
        if (bus_sel && !bus_wr && in_window) begin
            unique case (slot)
                SLOT_OUT:   rd_val = bank_q.out;
                SLOT_DIR:   rd_val = bank_q.dir;
                SLOT_BLINK: rd_val = bank_q.blink;
                SLOT_POL:   rd_val = bank_q.pol;
                SLOT_DIN:   rd_val = din_adj;
                SLOT_CAUSE: rd_val = bank_q.cause;
                SLOT_EMASK: rd_val = bank_q.emask;
                SLOT_LMASK: rd_val = bank_q.lmask;
                default:    rd_val = '0;
            endcase
        end
        bus_rdata = DATA_W'(rd_val);
    end

    assign out_q   = bank_q.out;
    assign dir_q   = bank_q.dir;
    assign blink_q = bank_q.blink;
    assign cause_q = bank_q.cause;
    assign emask_q = bank_q.emask;
    assign lmask_q = bank_q.lmask;
endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
    parameter int unsigned LINES = 32,
    parameter int unsigned GROUP = 8
) (
    input  logic [LINES-1:0]       din_adj,
    input  logic [LINES-1:0]       cause,
    input  logic [LINES-1:0]       emask,
    input  logic [LINES-1:0]       lmask,
    output logic [LINES/GROUP-1:0] irq_group
);
    localparam int unsigned NGRP = LINES / GROUP;

    logic [LINES-1:0] req;

    always_comb begin
        req = (din_adj & lmask) | (cause & emask);
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign irq_group[g] = |req[g*GROUP +: GROUP];
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
    parameter int unsigned NUM_LINES  = 32,
    parameter int unsigned GROUP_SIZE = 8,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned BLINK_DIV  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic [NUM_LINES-1:0]         pin_in,
    output logic [NUM_LINES-1:0]         pin_out,
    output logic [NUM_LINES-1:0]         pin_oe,
    output logic [NUM_LINES/GROUP_SIZE-1:0] irq_group
);
    localparam int unsigned NUM_GROUPS = NUM_LINES / GROUP_SIZE;

    logic [NUM_LINES-1:0] sync_lvl;
    logic [NUM_LINES-1:0] din_adj;
    logic [NUM_LINES-1:0] out_q;
    logic [NUM_LINES-1:0] dir_q;
    logic [NUM_LINES-1:0] blink_q;
    logic [NUM_LINES-1:0] cause_q;
    logic [NUM_LINES-1:0] emask_q;
    logic [NUM_LINES-1:0] lmask_q;
    logic                 blink_phase;

    gpio_sync2 #(.WIDTH(NUM_LINES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_lvl)
    );

    gpio_regbank #(
        .LINES  (NUM_LINES),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sync_lvl  (sync_lvl),
        .din_adj   (din_adj),
        .out_q     (out_q),
        .dir_q     (dir_q),
        .blink_q   (blink_q),
        .cause_q   (cause_q),
        .emask_q   (emask_q),
        .lmask_q   (lmask_q)
    );

    gpio_blink_gen #(.DIV(BLINK_DIV)) i_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (blink_phase)
    );

    gpio_irq_combine #(
        .LINES (NUM_LINES),
        .GROUP (GROUP_SIZE)
    ) i_combine (
        .din_adj   (din_adj),
        .cause     (cause_q),
        .emask     (emask_q),
        .lmask     (lmask_q),
        .irq_group (irq_group)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_pin
        assign pin_oe[i]  = ~dir_q[i];
        assign pin_out[i] = (blink_q[i] && !dir_q[i]) ? blink_phase : out_q[i];
    end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
    parameter int unsigned N_LINES  = 32,
    parameter int unsigned N_GROUPS = 4,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [N_LINES-1:0]  din_adj,
    input logic [N_LINES-1:0]  cause_q,
    input logic [N_LINES-1:0]  emask_q,
    input logic [N_LINES-1:0]  lmask_q,
    input logic [N_LINES-1:0]  blink_q,
    input logic [N_LINES-1:0]  pin_out,
    input logic [N_GROUPS-1:0] irq_group
);
    logic [N_LINES-1:0] seen_din;
    logic [N_LINES-1:0] rise;
    logic               cause_wr;
    logic               unmapped_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_din <= '0;
        else        seen_din <= din_adj;
    end

    always_comb begin
        rise        = din_adj & ~seen_din;
        cause_wr    = bus_sel && bus_wr && (bus_addr == ADDR_W'('h14));
        unmapped_rd = bus_sel && !bus_wr &&
                      ((bus_addr[1:0] != 2'b00) || (bus_addr > ADDR_W'('h1C)));
    end

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((cause_q & $past(rise)) == $past(rise)))
        else $error("edge not latched"); // R5

    AST_CAUSE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q & ~$past(cause_q) & ~$past(rise)) == '0)
        else $error("cause set without edge"); // R10

    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cause_wr |=> ((cause_q & ~$past(bus_wdata[N_LINES-1:0]) & ~$past(rise)) == '0))
        else $error("zero-written cause bit survived"); // R6

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (emask_q == '0 && lmask_q == '0) |-> (irq_group == '0))
        else $error("interrupt with all masks clear"); // R8

    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_sel && bus_wr) && blink_q == '0) |=> $stable(pin_out))
        else $error("pin changed without write"); // R3

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_rd |-> (bus_rdata == '0))
        else $error("unmapped read nonzero"); // R2
endmodule

bind gpio_irq_port gpio_irq_port_chk #(
    .N_LINES  (NUM_LINES),
    .N_GROUPS (NUM_GROUPS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) i_gpio_irq_port_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .din_adj   (din_adj),
    .cause_q   (cause_q),
    .emask_q   (emask_q),
    .lmask_q   (lmask_q),
    .blink_q   (blink_q),
    .pin_out   (pin_out),
    .irq_group (irq_group)
);

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
    localparam int unsigned DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [3:0]  irq_group;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_port #(.BLINK_DIV(DIV)) i_gpio_irq_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_group (irq_group)
    );

    localparam logic [7:0] A_OUT = 8'h00, A_DIR = 8'h04, A_BLINK = 8'h08,
                           A_POL = 8'h0C, A_DIN = 8'h10, A_CAUSE = 8'h14,
                           A_EMASK = 8'h18, A_LMASK = 8'h1C;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 irq", {28'h0, irq_group}, 32'h0);
        chk_reg("R1 out", A_OUT, 32'h0);
        chk_reg("R1 dir", A_DIR, 32'hFFFF_FFFF);
        chk_reg("R1 blink", A_BLINK, 32'h0);
        chk_reg("R1 pol", A_POL, 32'h0);
        chk_reg("R1 cause", A_CAUSE, 32'h0);
        chk_reg("R1 emask", A_EMASK, 32'h0);
        chk_reg("R1 lmask", A_LMASK, 32'h0);
    endtask

    task automatic t_regmap;
        wr(A_OUT, 32'hA5A5_0001);
        wr(A_BLINK, 32'h0F0F_0000);
        wr(A_EMASK, 32'h1234_5678);
        wr(A_LMASK, 32'h8765_4321);
        chk_reg("R2 out", A_OUT, 32'hA5A5_0001);
        chk_reg("R2 blink", A_BLINK, 32'h0F0F_0000);
        chk_reg("R2 emask", A_EMASK, 32'h1234_5678);
        chk_reg("R2 lmask", A_LMASK, 32'h8765_4321);
        wr(A_OUT, 32'h0); wr(A_BLINK, 32'h0); wr(A_EMASK, 32'h0); wr(A_LMASK, 32'h0);
        wr(A_POL, 32'h0000_F000);
        chk_reg("R2 pol", A_POL, 32'h0000_F000);
        chk_reg("R4 din follows pol", A_DIN, 32'h0000_F000);
        wr(A_DIN, 32'h1234_5678);
        chk_reg("R2 din write ignored", A_DIN, 32'h0000_F000);
        wr(A_POL, 32'h0);
        wr(A_CAUSE, 32'h0);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h05, 32'h0);
        chk_reg("R2 unmapped 0x20", 8'h20, 32'h0);
        chk_reg("R2 unaligned 0x05", 8'h05, 32'h0);
        chk_reg("R2 unmapped 0x7C", 8'h7C, 32'h0);
        chk_reg("R2 unaligned write ignored", A_DIR, 32'hFFFF_FFFF);
        chk_reg("R2 cause clean", A_CAUSE, 32'h0);
    endtask

    task automatic t_direction;
        wr(A_OUT, 32'h0000_00F0);
        wr(A_DIR, 32'hFFFF_FF0F);
        check("R3 oe", pin_oe, 32'h0000_00F0);
        check("R3 out", pin_out, 32'h0000_00F0);
        wr(A_DIR, 32'hFFFF_FFFF);
        check("R3 oe off", pin_oe, 32'h0);
        wr(A_OUT, 32'h0);
    endtask

    task automatic t_datain;
        @(negedge clk);
        pin_in = 32'h0000_0100;
        @(negedge clk);
        chk_reg("R4 one edge", A_DIN, 32'h0);
        @(negedge clk);
        chk_reg("R4 two edges", A_DIN, 32'h0000_0100);
        wr(A_POL, 32'h0000_0101);
        chk_reg("R4 inverted", A_DIN, 32'h0000_0001);
        wr(A_POL, 32'h0);
        set_pins(32'h0);
        wr(A_CAUSE, 32'h0);
    endtask

    task automatic t_edge;
        @(negedge clk);
        pin_in = 32'h0000_0008;
        repeat (2) @(negedge clk);
        chk_reg("R5 not yet", A_CAUSE, 32'h0);
        @(negedge clk);
        chk_reg("R5 rising latched", A_CAUSE, 32'h0000_0008);
        set_pins(32'h0);
        chk_reg("R10 held", A_CAUSE, 32'h0000_0008);
        set_pins(32'h0000_1000);
        wr(A_POL, 32'h0000_1000);
        wr(A_CAUSE, 32'h0);
        set_pins(32'h0);
        chk_reg("R5 falling latched", A_CAUSE, 32'h0000_1000);
        wr(A_POL, 32'h0);
        repeat (2) @(negedge clk);
        wr(A_CAUSE, 32'h0);
        chk_reg("R5 clean", A_CAUSE, 32'h0);
    endtask

    task automatic t_clear;
        set_pins(32'h0000_0306);
        chk_reg("R6 set", A_CAUSE, 32'h0000_0306);
        wr(A_CAUSE, ~32'h0000_0200);
        chk_reg("R6 clear one", A_CAUSE, 32'h0000_0106);
        wr(A_CAUSE, 32'h0000_0004);
        chk_reg("R6 keep ones", A_CAUSE, 32'h0000_0004);
        wr(A_CAUSE, 32'h0);
        chk_reg("R6 all cleared", A_CAUSE, 32'h0);
        set_pins(32'h0);
    endtask

    task automatic t_race;
        set_pins(32'h0000_0002);
        chk_reg("R7 pre", A_CAUSE, 32'h0000_0002);
        @(negedge clk);
        pin_in = 32'h0000_0003;
        @(negedge clk);
        wr(A_CAUSE, 32'h0);
        chk_reg("R7 event wins", A_CAUSE, 32'h0000_0001);
        set_pins(32'h0);
        wr(A_CAUSE, 32'h0);
    endtask

    task automatic t_irq;
        wr(A_LMASK, 32'h0000_0200);
        set_pins(32'h0000_0200);
        check("R8 level group1", {28'h0, irq_group}, 32'h2);
        set_pins(32'h0);
        check("R8 level drops", {28'h0, irq_group}, 32'h0);
        wr(A_LMASK, 32'h0);
        wr(A_CAUSE, 32'h0);
        wr(A_EMASK, 32'h0010_0000);
        set_pins(32'h0010_0000);
        check("R8 edge group2", {28'h0, irq_group}, 32'h4);
        set_pins(32'h0);
        check("R8 edge sticky", {28'h0, irq_group}, 32'h4);
        wr(A_CAUSE, 32'h0);
        check("R8 edge cleared", {28'h0, irq_group}, 32'h0);
        wr(A_EMASK, 32'h8000_0000);
        set_pins(32'h8000_0000);
        check("R8 line31 group3", {28'h0, irq_group}, 32'h8);
        set_pins(32'h0);
        wr(A_EMASK, 32'h0);
        wr(A_CAUSE, 32'h0);
        check("R8 quiet", {28'h0, irq_group}, 32'h0);
    endtask

    task automatic t_blink;
        int toggles;
        logic prev;
        wr(A_DIR, ~32'h0000_0020);
        wr(A_BLINK, 32'h0000_0020);
        check("R9 driven", pin_oe, 32'h0000_0020);
        toggles = 0;
        prev = pin_out[5];
        for (int k = 0; k < 2 * DIV; k++) begin
            @(negedge clk);
            if (pin_out[5] !== prev) toggles++;
            prev = pin_out[5];
        end
        check("R9 blink toggles", 32'(toggles), 32'd2);
        wr(A_BLINK, 32'h0);
        wr(A_OUT, 32'h0000_0020);
        toggles = 0;
        for (int k = 0; k < 2 * DIV; k++) begin
            @(negedge clk);
            if (pin_out[5] !== 1'b1) toggles++;
        end
        check("R9 steady output", 32'(toggles), 32'd0);
        wr(A_OUT, 32'h0);
        wr(A_DIR, 32'hFFFF_FFFF);
    endtask

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0; pin_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_direction();
        t_datain();
        t_edge();
        t_clear();
        t_race();
        t_irq();
        t_blink();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule